// File: doc/BRIEF.md
# Clock-Sampled Asynchronous Byte-Wide Memory with Write Lockout

This block models a byte-wide static memory that sits behind the classic three-strobe asynchronous bus: an active-low select, an active-low read strobe and an active-low write strobe. A fast system clock samples every pin. It classifies the bus into idle, read, write or locked. It forms the write window from the overlap of select and write strobe, and it decides when the data pins may be driven. The array is a plain register array. Its depth is `2**ADDR_W`, so `ADDR_W = 15` gives the full 32K x 8 organisation, and the default is a smaller 1K x 8.

A write window starts when the second of the two write-related strobes becomes active. It ends when the first of them becomes inactive. At that closing moment the block stores the byte on the data pins into the location on the address pins. The values seen earlier in the window have no effect. A separate active-high lockout input freezes the bus. While it is high, strobes are ignored, nothing is stored and the data pins are released. If lockout rises while a window is open, that write is dropped and does not resume. The data pins are presented as a data-out vector plus an output-enable, for a pad-level tri-state buffer.

Top module: `nvsram_bus_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `dq_oe` is 0.
- R2: With `lock` low, `sel_n`=0, `rd_n`=0 and `wr_n`=1, `dq_oe` is 1 and `dq_o` equals the byte last stored at `addr`.
- R3: A write commits exactly once per window. The window opens when the later of `sel_n`/`wr_n` goes low and closes when the earlier of them goes high. This holds for all three orderings: select first, write strobe first, and both together.
- R4: The stored address and byte are those on `addr` and `dq_i` when the window closes. Values present earlier in the window, or placed after the close, are not stored.
- R5: When `wr_n` falls during an active read, `dq_oe` drops to 0.
- R6: If `wr_n` is low before or together with `sel_n` falling, `dq_oe` stays 0 for the whole write, even with `rd_n` low.
- R7: With `rd_n` high during a write, `dq_oe` stays 0.
- R8: While `lock` is 1, `dq_oe` is 0 for every strobe combination and no write reaches the array.
- R9: A write window that is open when `lock` rises does not commit. This holds even if `lock` falls again before the window closes.
- R10: With `sel_n` high, `dq_oe` is 0 and toggling `wr_n` stores nothing.
- R11: `dq_oe` and `dq_o` follow a pin change exactly `SYNC_STAGES`+1 rising clock edges later (3 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write strobe |
| lock | input | 1 | Active-high write/access lockout |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data pins as seen by the block |
| dq_o | output | 8 | Read data toward the pad buffer |
| dq_oe | output | 1 | Drive enable for the pad buffer |

## Verification
Every pin passes through `SYNC_STAGES` flops, and then one more register forms the drive enable and the read data. A pin change applied between edges therefore shows on `dq_oe`/`dq_o` after the third following rising edge. The bench drives on the falling edge and samples on the falling edge three cycles later. The latency tests probe one cycle early as well, to confirm that nothing moves sooner. A store lands two edges after the closing strobe is seen. For this reason every write is followed by idle cycles before any readback, and a write's success or failure is judged only through a later read.

// File: rtl/nvsram_bus_pkg.sv
package nvsram_bus_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      BUS_IDLE   = 2'd0,
      BUS_READ   = 2'd1,
      BUS_WRITE  = 2'd2,
      BUS_LOCKED = 2'd3
   } bus_mode_t;

   typedef struct packed {
      logic lock;
      logic sel;
      logic rd;
      logic wr;
   } strobe_t;

   localparam int unsigned STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/nvsram_sync.sv
module nvsram_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin : chk_params
      assert (STAGES >= 1 && STAGES <= 4) else $error("nvsram_sync: STAGES out of range");
      assert (W >= 1) else $error("nvsram_sync: W must be positive");
   end

   logic [W-1:0] pipe [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= '0;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[gi] <= '0;
               else        pipe[gi] <= pipe[gi-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/nvsram_strobe_dec.sv
module nvsram_strobe_dec
   import nvsram_bus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  strobe_t   stb,
   output bus_mode_t mode,
   output logic      rd_drive,
   output logic      commit
);
   logic win;
   logic win_q;
   logic armed_q;
   logic open_edge;

   assign win       = stb.sel & stb.wr;
   assign open_edge = win & ~win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         win_q <= win;
         if (stb.lock)      armed_q <= 1'b0;
         else if (open_edge) armed_q <= 1'b1;
         else if (!win)     armed_q <= 1'b0;
      end
   end

   assign commit = armed_q & ~win & ~stb.lock;

   always_comb begin
      if (stb.lock)               mode = BUS_LOCKED;
      else if (win)               mode = BUS_WRITE;
      else if (stb.sel && stb.rd && !stb.wr) mode = BUS_READ;
      else                        mode = BUS_IDLE;
   end

   assign rd_drive = (mode == BUS_READ);

   p_lock_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stb.lock |-> !commit);
   p_lock_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stb.lock |=> !commit);
   p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);
   p_commit_when_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (!stb.sel || !stb.wr) && $past(stb.sel && stb.wr));
endmodule

// File: rtl/nvsram_array.sv
module nvsram_array #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvsram_bus_ctrl.sv
module nvsram_bus_ctrl
   import nvsram_bus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_READ    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              lock,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        dq_i,
   output logic [7:0]        dq_o,
   output logic              dq_oe
);
   localparam int unsigned BUNDLE_W = STROBE_W + ADDR_W + BYTE_W;

   initial begin : chk_params
      assert (ADDR_W >= 4 && ADDR_W <= 15) else $error("nvsram_bus_ctrl: ADDR_W out of range");
      assert (SYNC_STAGES >= 1) else $error("nvsram_bus_ctrl: need a sampling stage");
   end

   strobe_t           raw_stb;
   strobe_t           s_stb;
   logic [ADDR_W-1:0] s_addr;
   logic [BYTE_W-1:0] s_data;
   logic [BUNDLE_W-1:0] bundle_in;
   logic [BUNDLE_W-1:0] bundle_out;

   assign raw_stb.lock = lock;
   assign raw_stb.sel  = ~sel_n;
   assign raw_stb.rd   = ~rd_n;
   assign raw_stb.wr   = ~wr_n;
   assign bundle_in    = {raw_stb, addr, dq_i};

   nvsram_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bundle_in),
      .q     (bundle_out)
   );

   assign {s_stb, s_addr, s_data} = bundle_out;

   bus_mode_t mode;
   logic      rd_drive;
   logic      commit;

   nvsram_strobe_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (s_stb),
      .mode     (mode),
      .rd_drive (rd_drive),
      .commit   (commit)
   );

   logic [BYTE_W-1:0] rd_byte;

   nvsram_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
      .clk     (clk),
      .wr_en   (commit),
      .wr_addr (s_addr),
      .wr_data (s_data),
      .rd_addr (s_addr),
      .rd_data (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dq_oe <= 1'b0;
      else        dq_oe <= rd_drive;
   end

   generate
      if (REG_READ) begin : g_reg_read
         logic [BYTE_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_byte;
         end
         assign dq_o = rd_q;
      end else begin : g_comb_read
         assign dq_o = rd_byte;
      end
   endgenerate

   p_no_drive_on_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !commit);
   p_wr_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s_stb.wr |=> !dq_oe);
   p_desel_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !s_stb.sel |=> !dq_oe);
   p_lock_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_stb.lock |=> !dq_oe);
   p_mode_write_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_WRITE) |=> !dq_oe);
endmodule

// File: tb/sim_nvsram_bus_ctrl.sv
module sim_nvsram_bus_ctrl;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, lock = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    dq_i = '0;
   logic [7:0]    dq_o;
   logic          dq_oe;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] model [DEPTH];

   always #10 clk = ~clk;

   nvsram_bus_ctrl #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
      .lock(lock), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int a, input int salt);
      return 8'(((a * 7) + salt) ^ (a >> 2));
   endfunction

   task automatic go_idle();
      sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      tick(4);
   endtask

   // mode 0: wr first, sel closes first; 1: sel first, wr closes first; 2: together
   task automatic wr_byte(input int a, input logic [7:0] d, input int mode, input logic rd_low);
      rd_n = ~rd_low;
      addr = AW'(a ^ 1); dq_i = ~d;
      if (mode == 0) begin
         wr_n = 1'b0; tick(2); chk("R6 drive off", dq_oe, 0); sel_n = 1'b0;
      end else if (mode == 1) begin
         sel_n = 1'b0; tick(2); chk("R7 drive off", dq_oe, 0); wr_n = 1'b0;
      end else begin
         sel_n = 1'b0; wr_n = 1'b0;
      end
      tick(3); chk("R6 drive off in window", dq_oe, 0);
      addr = AW'(a); dq_i = d;
      tick(3); chk("R7 drive off in window", dq_oe, 0);
      if (mode == 0)      sel_n = 1'b1;
      else if (mode == 1) wr_n = 1'b1;
      else begin sel_n = 1'b1; wr_n = 1'b1; end
      tick(3); chk("R6 drive off after close", dq_oe, 0);
      addr = AW'(a ^ 2); dq_i = d ^ 8'h5a;
      tick(2);
      sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      tick(4);
      model[a] = d;
   endtask

   task automatic rd_chk(input int a, input string req);
      sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = AW'(a);
      tick(3);
      chk(req, dq_oe, 1);
      chk(req, dq_o, model[a]);
      go_idle();
   endtask

   initial begin : watchdog
      #(20 * 200000);
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      tick(3);
      chk("R1 reset drive", dq_oe, 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 after reset", dq_oe, 0);

      // R3/R4: fill the whole array, cycling the three strobe orderings
      for (int a = 0; a < DEPTH; a++) wr_byte(a, pat(a, 8'h35), a % 3, (a % 3) != 1);

      // R2: sweep reads while held in read state
      sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
      for (int a = 0; a < DEPTH; a++) begin
         addr = AW'(a);
         tick(3);
         chk("R2 read data", dq_o, model[a]);
         chk("R2 read drive", dq_oe, 1);
      end
      go_idle();

      // R11: exact latency of drive enable and data
      addr = AW'(5);
      sel_n = 1'b0; rd_n = 1'b0;
      tick(2); chk("R11 drive not early", dq_oe, 0);
      tick(1); chk("R11 drive on time", dq_oe, 1);
      addr = AW'(9);
      tick(2); chk("R11 data not early", dq_o, model[5]);
      tick(1); chk("R11 data on time", dq_o, model[9]);

      // R5: write strobe during read releases the pins
      wr_n = 1'b0;
      tick(2); chk("R5 still driving", dq_oe, 1);
      tick(1); chk("R5 released", dq_oe, 0);
      dq_i = model[9];
      go_idle();

      // R8/R10/R2: steady-state sweep of all strobe/lock combinations
      addr = AW'(17); dq_i = model[17];
      for (int c = 0; c < 16; c++) begin
         lock = c[3]; sel_n = c[2]; rd_n = c[1]; wr_n = c[0];
         tick(4);
         chk(c[3] ? "R8 lock sweep" : (c[2] ? "R10 deselect sweep" : "R2 decode sweep"),
             dq_oe, (!c[3] && !c[2] && !c[1] && c[0]) ? 1 : 0);
      end
      lock = 1'b0;
      go_idle();

      // R8: write attempt while locked
      lock = 1'b1; tick(3);
      addr = AW'(33); dq_i = ~model[33];
      sel_n = 1'b0; wr_n = 1'b0; tick(4);
      sel_n = 1'b1; wr_n = 1'b1; tick(4);
      lock = 1'b0; tick(4);
      rd_chk(33, "R8 locked write ignored");

      // R9: lock rises inside window and stays past the close
      addr = AW'(44); dq_i = ~model[44];
      sel_n = 1'b0; tick(1); wr_n = 1'b0; tick(4);
      lock = 1'b1; tick(4);
      wr_n = 1'b1; sel_n = 1'b1; tick(4);
      lock = 1'b0; tick(4);
      rd_chk(44, "R9 abort held lock");

      // R9: lock pulse inside window, released before the close
      addr = AW'(45); dq_i = ~model[45];
      sel_n = 1'b0; wr_n = 1'b0; tick(4);
      lock = 1'b1; tick(4);
      lock = 1'b0; tick(4);
      wr_n = 1'b1; sel_n = 1'b1; tick(4);
      rd_chk(45, "R9 abort pulsed lock");

      // R10: write strobe toggling while deselected
      addr = AW'(60); dq_i = ~model[60]; rd_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         wr_n = 1'b0; tick(3);
         chk("R10 no drive", dq_oe, 0);
         wr_n = 1'b1; tick(3);
      end
      rd_n = 1'b1;
      rd_chk(60, "R10 deselected write ignored");

      // R3/R4: a rewrite after lock tests stores once more, each ordering
      for (int m = 0; m < 3; m++) begin
         wr_byte(100 + m, 8'hc0 + 8'(m), m, 1'b0);
         rd_chk(100 + m, "R4 rewrite at close");
         rd_chk(100 + m + 1, "R3 neighbour untouched");
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule